// File: doc/BRIEF.md
# Selectable Hardware/Software Clock Gate Controller

This block decides, for one clock, whether that clock runs. Ownership of the decision belongs either to a hardware request line (auto-gating) or to a software enable bit, and a select bit in a 32-bit control register picks the owner. When hardware owns the gate, turning the clock on is immediate. Turning it off can be held back by a programmable hysteresis window, so that short idle gaps do not cause the clock to stop and restart. A read-only status bit follows the real gate state after a two-stage synchroniser, so software can poll it to learn that a requested change has completed.

A build parameter chooses one of four gate flavours:
- always-on (no gate);
- hardware-only;
- software-only;
- selectable hardware-or-software.

Register bits that a flavour cannot use read as zero, or as fixed values, and ignore writes. The gate itself is a registered enable output. The clock-gating cell is outside this block.

A three-state machine drives the gate:
- ST_ON: the clock runs.
- ST_DRAIN: the hardware request has dropped and the hysteresis timer is counting.
- ST_OFF: the clock is stopped.

Its transitions are:
- ON->OFF: a software disable, or a hardware idle while hysteresis is off.
- ON->DRAIN: a hardware idle while hysteresis is on.
- DRAIN->ON: the request returns, or software enables.
- DRAIN->OFF: the timer expires, hysteresis is switched off, or software disables.
- OFF->ON: the current owner requests the clock.

Top module: `clkgate_ctl`

## Requirements
- R1: After reset `gate_en` is 1. Read data shows bit0 = 1 for flavours with a software enable (else 0), bit1 = 1 only in the software-only flavour, bits 2 and 3 = 0, and bit8 (status) = 1.
- R2: Register layout: bit0 is the software enable (1 = run), bit1 is the owner select (0 = hardware, 1 = software), bit2 is the hysteresis enable, and bit3 picks the long window (1) or the short window (0). bit8 is the read-only gate status. All other bits read 0, and writes to them (including bit8) have no effect.
- R3: With hardware as owner, a high `hw_req` sampled at a clock edge makes `gate_en` 1 right after that edge, including while draining.
- R4: With hardware as owner and bit2 = 0, a low `hw_req` sampled at an edge makes `gate_en` 0 right after that edge.
- R5: With hardware as owner and bit2 = 1, `gate_en` falls at the N-th edge after the first edge that samples `hw_req` low, and only if `hw_req` is low at all of those edges. N is SHORT_DLY when bit3 = 0 and LONG_DLY when bit3 = 1. A high sample before then keeps the clock on.
- R6: With software as owner, `gate_en` after an edge equals bit0 as it was stored before that edge. `hw_req` and hysteresis have no effect.
- R7: Status bit8 equals the value `gate_en` had two edges earlier.
- R8: An owner change leaves `gate_en` unchanged while the new owner's request matches the current state. If the request differs, the new owner takes effect at the next edge.
- R9: In the hardware-only flavour, bits 0 and 1 read 0 and ignore writes, and hardware always owns the gate.
- R10: In the software-only flavour, bit1 reads 1, bits 2 and 3 read 0, and `hw_req` is ignored.
- R11: In the always-on flavour, `gate_en` is always 1, bits 0 to 3 read 0, and status reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Write strobe for the control register |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Control fields plus live gate status |
| hw_req | input | 1 | Hardware clock request (1 = clock needed) |
| gate_en | output | 1 | Registered, glitch-free clock enable |

## Verification
The bench sweeps every idle-pulse length from 1 up to the window, for both hysteresis windows, and then lets the request stay low for a full window. A timer that is off by one would stop the clock on the longest pulse that should be tolerated, or would hold it one edge too long. It hands ownership between hardware and software both with matching requests and with differing requests. A design that reacts to the select write itself would glitch the enable in the matching case. It polls the status bit edge by edge after each change to confirm the two-edge lag. It also writes all-ones patterns into each flavour, which exposes fields that should be tied but are stored.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    typedef enum logic [1:0] {
        GF_NONE    = 2'd0,
        GF_HW_ONLY = 2'd1,
        GF_SW_ONLY = 2'd2,
        GF_HW_SW   = 2'd3
    } gate_flavour_e;

    typedef enum logic [1:0] {
        ST_ON    = 2'd0,
        ST_DRAIN = 2'd1,
        ST_OFF   = 2'd2
    } gate_state_e;

    localparam int unsigned BIT_SW_EN     = 0;
    localparam int unsigned BIT_OWNER     = 1;
    localparam int unsigned BIT_HYST_EN   = 2;
    localparam int unsigned BIT_HYST_LONG = 3;
    localparam int unsigned BIT_STATUS    = 8;

    typedef struct packed {
        logic hyst_long;
        logic hyst_en;
        logic owner_sw;
        logic sw_en;
    } gate_ctrl_t;

    function automatic bit flavour_has_hw(gate_flavour_e f);
        return (f == GF_HW_ONLY) || (f == GF_HW_SW);
    endfunction

    function automatic bit flavour_has_sw(gate_flavour_e f);
        return (f == GF_SW_ONLY) || (f == GF_HW_SW);
    endfunction

endpackage

// File: rtl/clkgate_regs.sv
module clkgate_regs
    import clkgate_pkg::*;
#(
    parameter gate_flavour_e FLAVOUR = GF_HW_SW,
    parameter int unsigned   REG_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             status,
    output gate_ctrl_t       ctrl,
    output logic [REG_W-1:0] rdata
);

    localparam bit HAS_HW = flavour_has_hw(FLAVOUR);
    localparam bit HAS_SW = flavour_has_sw(FLAVOUR);

    logic sw_en_q;
    logic owner_q;
    logic hyst_en_q;
    logic hyst_long_q;
    logic unused_wdata;

    assign unused_wdata = ^wdata;

    // software enable field exists only when software can own the gate
    generate
        if (HAS_SW) begin : g_sw_en
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sw_en_q <= 1'b1;
                end else if (we) begin
                    sw_en_q <= wdata[BIT_SW_EN];
                end
            end
        end else begin : g_no_sw_en
            assign sw_en_q = 1'b0;
        end
    endgenerate

    // owner select is writable only in the selectable flavour
    generate
        if (FLAVOUR == GF_HW_SW) begin : g_owner
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    owner_q <= 1'b0;
                end else if (we) begin
                    owner_q <= wdata[BIT_OWNER];
                end
            end
        end else begin : g_owner_tied
            assign owner_q = (FLAVOUR == GF_SW_ONLY);
        end
    endgenerate

    // hysteresis only applies to hardware-initiated gate-off
    generate
        if (HAS_HW) begin : g_hyst
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hyst_en_q   <= 1'b0;
                    hyst_long_q <= 1'b0;
                end else if (we) begin
                    hyst_en_q   <= wdata[BIT_HYST_EN];
                    hyst_long_q <= wdata[BIT_HYST_LONG];
                end
            end
        end else begin : g_no_hyst
            assign hyst_en_q   = 1'b0;
            assign hyst_long_q = 1'b0;
        end
    endgenerate

    always_comb begin
        ctrl.sw_en     = sw_en_q;
        ctrl.owner_sw  = owner_q;
        ctrl.hyst_en   = hyst_en_q;
        ctrl.hyst_long = hyst_long_q;
    end

    always_comb begin
        rdata                = '0;
        rdata[BIT_SW_EN]     = sw_en_q;
        rdata[BIT_OWNER]     = owner_q;
        rdata[BIT_HYST_EN]   = hyst_en_q;
        rdata[BIT_HYST_LONG] = hyst_long_q;
        rdata[BIT_STATUS]    = status;
    end

endmodule

// File: rtl/clkgate_hyst_timer.sv
module clkgate_hyst_timer #(
    parameter int unsigned SHORT_DLY = 8,
    parameter int unsigned LONG_DLY  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sel_long,
    input  logic run,
    output logic done
);

    localparam int unsigned CW = (LONG_DLY > 1) ? $clog2(LONG_DLY) : 1;
    localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_DLY - 1);
    localparam logic [CW-1:0] LONG_LD  = CW'(LONG_DLY - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= sel_long ? LONG_LD : SHORT_LD;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/clkgate_fsm.sv
module clkgate_fsm
    import clkgate_pkg::*;
#(
    parameter gate_flavour_e FLAVOUR = GF_HW_SW
) (
    input  logic clk,
    input  logic rst_n,
    input  logic owner_sw,
    input  logic sw_en,
    input  logic hyst_en,
    input  logic hw_req,
    input  logic tmr_done,
    output logic tmr_load,
    output logic tmr_run,
    output logic gate_en
);

    gate_state_e state_q;
    gate_state_e state_d;
    logic        gate_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ON;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ON: begin
                if (owner_sw) begin
                    if (!sw_en) state_d = ST_OFF;
                end else if (!hw_req) begin
                    state_d = hyst_en ? ST_DRAIN : ST_OFF;
                end
            end
            ST_DRAIN: begin
                if (owner_sw) begin
                    state_d = sw_en ? ST_ON : ST_OFF;
                end else if (hw_req) begin
                    state_d = ST_ON;
                end else if (!hyst_en || tmr_done) begin
                    state_d = ST_OFF;
                end
            end
            ST_OFF: begin
                if (owner_sw ? sw_en : hw_req) state_d = ST_ON;
            end
            default: state_d = ST_ON;
        endcase
        if (FLAVOUR == GF_NONE) state_d = ST_ON;
    end

    // outputs: timer control and the registered enable
    always_comb begin
        tmr_load = (state_q == ST_ON) && (state_d == ST_DRAIN);
        tmr_run  = (state_q == ST_DRAIN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b1;
        end else begin
            gate_q <= (state_d != ST_OFF);
        end
    end

    assign gate_en = gate_q;

endmodule

// File: rtl/clkgate_status_sync.sv
module clkgate_status_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sync_q[STAGES-1];

endmodule

// File: rtl/clkgate_ctl.sv
module clkgate_ctl
    import clkgate_pkg::*;
#(
    parameter gate_flavour_e FLAVOUR     = GF_HW_SW,
    parameter int unsigned   REG_W       = 32,
    parameter int unsigned   SHORT_DLY   = 8,
    parameter int unsigned   LONG_DLY    = 64,
    parameter int unsigned   SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             hw_req,
    output logic             gate_en
);

    gate_ctrl_t ctrl;
    logic       status;
    logic       tmr_load;
    logic       tmr_run;
    logic       tmr_done;

    clkgate_regs #(
        .FLAVOUR (FLAVOUR),
        .REG_W   (REG_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .wdata  (reg_wdata),
        .status (status),
        .ctrl   (ctrl),
        .rdata  (reg_rdata)
    );

    clkgate_hyst_timer #(
        .SHORT_DLY (SHORT_DLY),
        .LONG_DLY  (LONG_DLY)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .sel_long (ctrl.hyst_long),
        .run      (tmr_run),
        .done     (tmr_done)
    );

    clkgate_fsm #(
        .FLAVOUR (FLAVOUR)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .owner_sw (ctrl.owner_sw),
        .sw_en    (ctrl.sw_en),
        .hyst_en  (ctrl.hyst_en),
        .hw_req   (hw_req),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .tmr_run  (tmr_run),
        .gate_en  (gate_en)
    );

    clkgate_status_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gate_en),
        .q     (status)
    );

endmodule

// File: rtl/clkgate_ctl_chk.sv
module clkgate_ctl_chk
    import clkgate_pkg::*;
#(
    parameter gate_flavour_e FLAVOUR = GF_HW_SW,
    parameter int unsigned   REG_W   = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] reg_rdata,
    input logic             hw_req,
    input logic             gate_en
);

    localparam bit HAS_HW = flavour_has_hw(FLAVOUR);
    localparam logic [REG_W-1:0] USED_MASK =
        (REG_W'(1) << BIT_STATUS) | REG_W'(4'hF);

    logic hw_owns;
    assign hw_owns = HAS_HW && !reg_rdata[BIT_OWNER];

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (reg_rdata & ~USED_MASK) == '0); // R2
    AST_HW_WAKE: assert property (@(posedge clk) disable iff (!rst_n) (hw_owns && hw_req) |=> gate_en); // R3
    AST_HW_DROP_FAST: assert property (@(posedge clk) disable iff (!rst_n) (hw_owns && !hw_req && !reg_rdata[BIT_HYST_EN]) |=> !gate_en); // R4
    AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ($past(hw_req) && gate_en && !hw_req && hw_owns && reg_rdata[BIT_HYST_EN]) |=> gate_en); // R5
    AST_SW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) reg_rdata[BIT_OWNER] |=> (gate_en == $past(reg_rdata[BIT_SW_EN]))); // R6
    AST_STATUS_LAG: assert property (@(posedge clk) disable iff (!rst_n) reg_rdata[BIT_STATUS] == $past(gate_en, 2)); // R7
    AST_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n) (FLAVOUR == GF_NONE) |-> gate_en); // R11

endmodule

bind clkgate_ctl clkgate_ctl_chk #(
    .FLAVOUR (FLAVOUR),
    .REG_W   (REG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .hw_req    (hw_req),
    .gate_en   (gate_en)
);

// File: tb/clkgate_ctl_tb_top.sv
module clkgate_ctl_tb_top;
    import clkgate_pkg::*;

    localparam int S = 3;
    localparam int L = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_req = 1'b1;
    logic [31:0] wdata = '0;
    logic        we_a = 1'b0, we_h = 1'b0, we_s = 1'b0, we_n = 1'b0;
    logic [31:0] rd_a, rd_h, rd_s, rd_n;
    logic        ge_a, ge_h, ge_s, ge_n;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    clkgate_ctl #(.FLAVOUR(GF_HW_SW), .SHORT_DLY(S), .LONG_DLY(L)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(we_a), .reg_wdata(wdata),
        .reg_rdata(rd_a), .hw_req(hw_req), .gate_en(ge_a));
    clkgate_ctl #(.FLAVOUR(GF_HW_ONLY), .SHORT_DLY(S), .LONG_DLY(L)) dut_hw (
        .clk(clk), .rst_n(rst_n), .reg_we(we_h), .reg_wdata(wdata),
        .reg_rdata(rd_h), .hw_req(hw_req), .gate_en(ge_h));
    clkgate_ctl #(.FLAVOUR(GF_SW_ONLY), .SHORT_DLY(S), .LONG_DLY(L)) dut_sw (
        .clk(clk), .rst_n(rst_n), .reg_we(we_s), .reg_wdata(wdata),
        .reg_rdata(rd_s), .hw_req(hw_req), .gate_en(ge_s));
    clkgate_ctl #(.FLAVOUR(GF_NONE), .SHORT_DLY(S), .LONG_DLY(L)) dut_none (
        .clk(clk), .rst_n(rst_n), .reg_we(we_n), .reg_wdata(wdata),
        .reg_rdata(rd_n), .hw_req(hw_req), .gate_en(ge_n));

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // expected read value: status at bit8, fields at bits 3:0
    function automatic logic [31:0] rd_exp(input logic [3:0] f, input logic st);
        return {23'b0, st, 4'b0, f};
    endfunction

    task automatic write_reg(input int which, input logic [31:0] v);
        wdata = v;
        case (which)
            0: we_a = 1'b1;
            1: we_h = 1'b1;
            2: we_s = 1'b1;
            default: we_n = 1'b1;
        endcase
        step(1);
        we_a = 1'b0; we_h = 1'b0; we_s = 1'b0; we_n = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        step(5);
        rst_n = 1'b1;
        step(1);

        // R1 reset state of every flavour
        check("R1", {31'b0, ge_a}, 32'd1, "sel gate_en");
        check("R1", rd_a, rd_exp(4'b0001, 1'b1), "sel rdata");
        check("R1", rd_h, rd_exp(4'b0000, 1'b1), "hw rdata");
        check("R1", rd_s, rd_exp(4'b0011, 1'b1), "sw rdata");
        check("R1", rd_n, rd_exp(4'b0000, 1'b1), "none rdata");

        // R4 immediate hardware gate-off, R7 status lag
        hw_req = 1'b0;
        step(1);
        check("R4", {31'b0, ge_a}, 32'd0, "drop no hyst");
        check("R7", {31'b0, rd_a[8]}, 32'd1, "status edge0");
        step(1);
        check("R7", {31'b0, rd_a[8]}, 32'd1, "status edge1");
        step(1);
        check("R7", {31'b0, rd_a[8]}, 32'd0, "status edge2");

        // R3 immediate gate-on
        hw_req = 1'b1;
        step(1);
        check("R3", {31'b0, ge_a}, 32'd1, "wake");

        // R5 sweep of idle lengths for both windows
        for (int lng = 0; lng < 2; lng++) begin
            int n_win;
            n_win = (lng != 0) ? L : S;
            write_reg(0, {28'b0, lng[0], 1'b1, 1'b0, 1'b1});
            for (int len = 1; len <= n_win; len++) begin
                hw_req = 1'b0;
                for (int j = 0; j < len; j++) begin
                    step(1);
                    check("R5", {31'b0, ge_a}, 32'd1, "short idle held");
                end
                hw_req = 1'b1;
                step(1);
                check("R5", {31'b0, ge_a}, 32'd1, "after pulse");
            end
            hw_req = 1'b0;
            for (int j = 0; j < n_win; j++) begin
                step(1);
                check("R5", {31'b0, ge_a}, 32'd1, "draining");
            end
            step(1);
            check("R5", {31'b0, ge_a}, 32'd0, "window expired");
            hw_req = 1'b1;
            step(1);
            check("R3", {31'b0, ge_a}, 32'd1, "wake after drain");
        end

        // R6 software ownership
        write_reg(0, 32'h7);
        hw_req = 1'b0;
        step(3);
        check("R6", {31'b0, ge_a}, 32'd1, "hw idle ignored");
        write_reg(0, 32'h6);
        check("R6", {31'b0, ge_a}, 32'd1, "before sample");
        step(1);
        check("R6", {31'b0, ge_a}, 32'd0, "sw off no hyst");
        step(1);
        check("R7", {31'b0, rd_a[8]}, 32'd1, "sw status edge1");
        step(1);
        check("R7", {31'b0, rd_a[8]}, 32'd0, "sw status edge2");
        hw_req = 1'b1;
        step(3);
        check("R6", {31'b0, ge_a}, 32'd0, "hw req ignored");

        // R8 owner change, matching request: no change
        hw_req = 1'b0;
        write_reg(0, 32'h0);
        step(3);
        check("R8", {31'b0, ge_a}, 32'd0, "match stays off");
        hw_req = 1'b1;
        step(1);
        check("R3", {31'b0, ge_a}, 32'd1, "hw takes over");

        // R8 owner change, differing request
        write_reg(0, 32'h3);
        hw_req = 1'b0;
        step(2);
        check("R8", {31'b0, ge_a}, 32'd1, "sw keeps on");
        write_reg(0, 32'h1);
        check("R8", {31'b0, ge_a}, 32'd1, "switch edge");
        step(1);
        check("R8", {31'b0, ge_a}, 32'd0, "hw idle applies");

        // R2 reserved bits and read-only status
        write_reg(0, 32'hFFFF_FFF0);
        step(2);
        check("R2", rd_a, rd_exp(4'b0000, 1'b0), "reserved ignored");
        write_reg(0, 32'h0000_0106);
        step(1);
        check("R2", rd_a, rd_exp(4'b0110, 1'b0), "status read-only");

        // R9 hardware-only flavour
        write_reg(1, 32'h0000_000F);
        check("R9", rd_h, rd_exp(4'b1100, 1'b0), "hw rdata");
        hw_req = 1'b1;
        step(1);
        check("R9", {31'b0, ge_h}, 32'd1, "hw wake");
        hw_req = 1'b0;
        for (int j = 0; j < L; j++) begin
            step(1);
            check("R9", {31'b0, ge_h}, 32'd1, "hw long drain");
        end
        step(1);
        check("R9", {31'b0, ge_h}, 32'd0, "hw long expire");

        // R10 software-only flavour
        step(2);
        check("R10", {31'b0, ge_s}, 32'd1, "sw ignores idle");
        write_reg(2, 32'h0000_000D);
        check("R10", rd_s, rd_exp(4'b0011, 1'b1), "sw rdata");
        write_reg(2, 32'h0);
        step(1);
        check("R10", {31'b0, ge_s}, 32'd0, "sw off");
        hw_req = 1'b1;
        step(2);
        check("R10", {31'b0, ge_s}, 32'd0, "sw ignores req");

        // R11 always-on flavour
        write_reg(3, 32'h0000_000F);
        check("R11", rd_n, rd_exp(4'b0000, 1'b1), "none rdata");
        write_reg(3, 32'h0);
        hw_req = 1'b0;
        step(3);
        check("R11", {31'b0, ge_n}, 32'd1, "none on");
        check("R11", rd_n, rd_exp(4'b0000, 1'b1), "none status");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule